// File: doc/BRIEF.md
# Secure Register-Range Clear Sequencer

This block carries out a secure-state request to zero a contiguous range of floating-point registers held in a 64-entry file of 32-bit (single) registers. A request names a first register, a register count and whether the indices are single or double (paired) registers. The block first screens the request against the core's status: security state, main-extension presence, FP and vector hardware presence, the upper double-register bank, the automatic-context-save and secure-FP-owned flags, and whether FP access is currently enabled. It then resolves the range into single-register indices and either faults, completes as a no-operation, or walks the range.

During the walk it issues one zeroing write per cycle on a write port toward the register file. A write is 64 bits wide (two singles, even index) wherever alignment allows, and 32 bits at an odd first register or a lone last even register. When the vector extension is present, a predicate-clear strobe accompanies the completion pulse. Every request, whatever its outcome, ends with a one-cycle `done` pulse that carries the fault flags.

Top module: `rclr_top`

## Requirements
- R1: When `secureState` is 0 or `mainExt` is 0, a request ends with `done` and `faultUndef` both 1, with no writes; this check takes precedence over every other outcome.
- R2: When both `fpPresent` and `vecPresent` are 0 (and R1 does not apply), the request ends with `done` alone: no fault, no write, `predClr` 0.
- R3: When `fpCtxAutoEn` is 1 and `secFpOwned` is 0, no FP context is active: the request ends with `done` alone, no write, no `predClr`, and no coprocessor-disabled fault even when `fpAccessOk` is 0.
- R4: Otherwise, when `fpAccessOk` is 0, the request ends with `done` and `faultNocp`, no writes, and this fault takes precedence over an illegal range (R6).
- R5: For `isDouble`=0 the range is singles `startIdx` to `startIdx+regCount-1`; for `isDouble`=1 it is singles `2*startIdx` to `2*(startIdx+regCount-1)+1`.
- R6: A resolved top index above 63, or an even top index above 31, ends with `done` and `faultUndef` and no writes.
- R7: When `upperBank` is 0, a legal top index above 31 is clamped to 31; a range then lying wholly above 31 produces no writes.
- R8: The walk starts in the cycle after the accepted `start`, one write per cycle with `wrEn`=1: an odd first index is a 32-bit write (`wrWide`=0), then each pair at an even `wrIdx` is a 64-bit write (`wrWide`=1), and a final lone even index is a 32-bit write; every index in the range is zeroed exactly once, in ascending order.
- R9: A request that reaches the range stage without a fault asserts `predClr` together with `done` exactly when `vecPresent` is 1; faulted or no-op requests never assert it.
- R10: `done` is a one-cycle pulse in the cycle after the last write (or the cycle after `start` when there is no write); `busy` is 1 from the cycle after `start` through the `done` cycle, and a `start` seen while busy is ignored.
- R11: A `regCount` of 0 that passes R1 to R4 produces no write and ends with `done` (with `predClr` per R9).
- R12: After reset, `busy`, `done`, `wrEn`, `predClr` and both faults are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when not busy |
| startIdx | input | 5 | First register (single or double units) |
| regCount | input | 7 | Number of registers in the range |
| isDouble | input | 1 | 1: indices are double registers |
| secureState | input | 1 | 1: core is in secure state |
| mainExt | input | 1 | 1: main extension implemented |
| fpPresent | input | 1 | 1: FP hardware present |
| vecPresent | input | 1 | 1: vector extension present |
| upperBank | input | 1 | 1: upper 16 double registers exist |
| fpCtxAutoEn | input | 1 | Automatic FP context save enabled |
| secFpOwned | input | 1 | Secure state owns the FP context |
| fpAccessOk | input | 1 | FP access enable check passes |
| busy | output | 1 | Request in progress |
| wrEn | output | 1 | Zeroing write strobe |
| wrWide | output | 1 | 1: 64-bit write of pair wrIdx, wrIdx+1 |
| wrIdx | output | 6 | Single-register index of the write |
| predClr | output | 1 | Zero the predicate register (with done) |
| done | output | 1 | Request complete, one-cycle pulse |
| faultUndef | output | 1 | Undefined-instruction fault (with done) |
| faultNocp | output | 1 | Coprocessor-disabled fault (with done) |

## Verification
Directed requests pin down each screening outcome and its precedence: non-secure and missing main extension against everything else, the inactive-context no-op with access disabled (telling R3 apart from R4), and a disabled-access request with an illegal range (telling R4 apart from R6). Range shapes then separate the walk edges: odd and even first indices, odd and even last indices, double-register conversion, a clamped top, a double range sitting wholly above the low bank, and a zero count. Several hundred random requests, biased toward legal status, compare the exact write sequence, flags and completion cycle against a bench model, and some of them raise `start` again while busy with a different range to show that the running walk is unaffected.

// File: rtl/rclr_pkg.sv
package rclr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // latch resolved bottom/top into the walk registers
    logic step;  // issue the current write and advance the cursor
  } dpStrobes_t;

endpackage

// File: rtl/rclr_datapath.sv
module rclr_datapath
  import rclr_pkg::*;
#(
  parameter int NUM_SREG = 64,
  parameter int START_W  = 5,
  parameter int COUNT_W  = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobes_t                  strobes,
  input  logic [START_W-1:0]          startIdx,
  input  logic [COUNT_W-1:0]          regCount,
  input  logic                        isDouble,
  input  logic                        upperBank,
  output logic                        rangeIllegal,
  output logic                        rangeEmpty,
  output logic                        walkLast,
  output logic                        wrEn,
  output logic                        wrWide,
  output logic [$clog2(NUM_SREG)-1:0] wrIdx
);

  localparam int IDX_W = $clog2(NUM_SREG);
  localparam int CUR_W = IDX_W + 1;
  localparam int TOP_W = ((START_W > COUNT_W) ? START_W : COUNT_W) + 2;
  localparam logic [TOP_W-1:0] TOP_MAX = TOP_W'(NUM_SREG - 1);
  localparam logic [TOP_W-1:0] TOP_LOW = TOP_W'(NUM_SREG / 2 - 1);
  localparam logic [CUR_W-1:0] CUR_LOW = CUR_W'(NUM_SREG / 2 - 1);

  // Range resolution, evaluated while a request is presented
  logic [TOP_W-1:0] spanTop, topRaw;
  logic [CUR_W-1:0] bottom, topEff;
  logic             countZero;

  always_comb begin
    countZero = (regCount == '0);
    spanTop   = TOP_W'(startIdx) + TOP_W'(regCount) - TOP_W'(1);
    topRaw    = isDouble ? {spanTop[TOP_W-2:0], 1'b1} : spanTop;
    bottom    = isDouble ? CUR_W'({startIdx, 1'b0}) : CUR_W'(startIdx);
    rangeIllegal = !countZero &&
                   ((topRaw > TOP_MAX) || ((topRaw > TOP_LOW) && !topRaw[0]));
    topEff    = (!upperBank && (topRaw > TOP_LOW)) ? CUR_LOW : CUR_W'(topRaw);
    rangeEmpty = countZero || (topEff < bottom);
  end

  // Walk registers
  logic [CUR_W-1:0] cursor, topReg, cursorNext;
  logic             wideNow;

  always_comb begin
    wideNow    = !cursor[0] && (cursor < topReg);
    cursorNext = cursor + (wideNow ? CUR_W'(2) : CUR_W'(1));
    walkLast   = (cursorNext > topReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cursor <= '0;
      topReg <= '0;
    end else if (strobes.load) begin
      cursor <= bottom;
      topReg <= topEff;
    end else if (strobes.step) begin
      cursor <= cursorNext;
    end
  end

  assign wrEn   = strobes.step;
  assign wrWide = strobes.step && wideNow;
  assign wrIdx  = cursor[IDX_W-1:0];

  // R8: a 64-bit write always starts on an even single
  p_wide_even_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrWide |-> !wrIdx[0]);

  // R7: no write beyond the latched top
  p_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (cursor <= topReg));

  // R7: without the upper bank the latched top stays in the low half
  p_clamped_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !upperBank) |=> (topReg <= CUR_LOW));

  // R8: consecutive writes advance by the width of the previous write
  p_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !walkLast) |=>
      (wrEn && (cursor == $past(cursor) + ($past(wrWide) ? CUR_W'(2) : CUR_W'(1)))));

endmodule

// File: rtl/rclr_ctrl.sv
module rclr_ctrl
  import rclr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       secureState,
  input  logic       mainExt,
  input  logic       fpPresent,
  input  logic       vecPresent,
  input  logic       fpCtxAutoEn,
  input  logic       secFpOwned,
  input  logic       fpAccessOk,
  input  logic       rangeIllegal,
  input  logic       rangeEmpty,
  input  logic       walkLast,
  output dpStrobes_t strobes,
  output logic       busy,
  output logic       done,
  output logic       predClr,
  output logic       faultUndef,
  output logic       faultNocp
);

  seqState_t state;
  logic      flagUndef, flagNocp, flagPred;
  logic      denyUndef, noHw, ctxIdle, goWalk;

  always_comb begin
    denyUndef = !secureState || !mainExt;
    noHw      = !fpPresent && !vecPresent;
    ctxIdle   = fpCtxAutoEn && !secFpOwned;
    goWalk    = !denyUndef && !noHw && !ctxIdle && fpAccessOk &&
                !rangeIllegal && !rangeEmpty;
    strobes.load = (state == ST_IDLE) && start && goWalk;
    strobes.step = (state == ST_WALK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      flagUndef <= 1'b0;
      flagNocp  <= 1'b0;
      flagPred  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          flagUndef <= 1'b0;
          flagNocp  <= 1'b0;
          flagPred  <= 1'b0;
          state     <= ST_DONE;
          if (denyUndef) begin
            flagUndef <= 1'b1;
          end else if (noHw || ctxIdle) begin
            flagPred  <= 1'b0;
          end else if (!fpAccessOk) begin
            flagNocp  <= 1'b1;
          end else if (rangeIllegal) begin
            flagUndef <= 1'b1;
          end else begin
            flagPred  <= vecPresent;
            if (!rangeEmpty) state <= ST_WALK;
          end
        end
        ST_WALK: if (walkLast) state <= ST_DONE;
        ST_DONE: begin
          state     <= ST_IDLE;
          flagUndef <= 1'b0;
          flagNocp  <= 1'b0;
          flagPred  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign faultUndef = done && flagUndef;
  assign faultNocp  = done && flagNocp;
  assign predClr    = done && flagPred;

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: the two faults never report together
  p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(faultUndef && faultNocp));

  // R9: a faulted request never clears the predicate
  p_fault_no_pred_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultUndef || faultNocp) |-> !predClr);

endmodule

// File: rtl/rclr_top.sv
module rclr_top
  import rclr_pkg::*;
#(
  parameter int NUM_SREG = 64,
  parameter int START_W  = 5,
  parameter int COUNT_W  = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [START_W-1:0]          startIdx,
  input  logic [COUNT_W-1:0]          regCount,
  input  logic                        isDouble,
  input  logic                        secureState,
  input  logic                        mainExt,
  input  logic                        fpPresent,
  input  logic                        vecPresent,
  input  logic                        upperBank,
  input  logic                        fpCtxAutoEn,
  input  logic                        secFpOwned,
  input  logic                        fpAccessOk,
  output logic                        busy,
  output logic                        wrEn,
  output logic                        wrWide,
  output logic [$clog2(NUM_SREG)-1:0] wrIdx,
  output logic                        predClr,
  output logic                        done,
  output logic                        faultUndef,
  output logic                        faultNocp
);

  dpStrobes_t strobes;
  logic       rangeIllegal, rangeEmpty, walkLast;

  rclr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .secureState  (secureState),
    .mainExt      (mainExt),
    .fpPresent    (fpPresent),
    .vecPresent   (vecPresent),
    .fpCtxAutoEn  (fpCtxAutoEn),
    .secFpOwned   (secFpOwned),
    .fpAccessOk   (fpAccessOk),
    .rangeIllegal (rangeIllegal),
    .rangeEmpty   (rangeEmpty),
    .walkLast     (walkLast),
    .strobes      (strobes),
    .busy         (busy),
    .done         (done),
    .predClr      (predClr),
    .faultUndef   (faultUndef),
    .faultNocp    (faultNocp)
  );

  rclr_datapath #(
    .NUM_SREG (NUM_SREG),
    .START_W  (START_W),
    .COUNT_W  (COUNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .startIdx     (startIdx),
    .regCount     (regCount),
    .isDouble     (isDouble),
    .upperBank    (upperBank),
    .rangeIllegal (rangeIllegal),
    .rangeEmpty   (rangeEmpty),
    .walkLast     (walkLast),
    .wrEn         (wrEn),
    .wrWide       (wrWide),
    .wrIdx        (wrIdx)
  );

  // R10: a start while busy never ends the current request early
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);

  // R8: no zeroing write in the completion cycle
  p_no_write_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);

endmodule

// File: tb/rclr_top_tb.sv
`timescale 1ns/1ps
module rclr_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [4:0] startIdx = '0;
  logic [6:0] regCount = '0;
  logic       isDouble = 1'b0, secureState = 1'b0, mainExt = 1'b0;
  logic       fpPresent = 1'b0, vecPresent = 1'b0, upperBank = 1'b0;
  logic       fpCtxAutoEn = 1'b0, secFpOwned = 1'b0, fpAccessOk = 1'b0;
  logic       busy, wrEn, wrWide, predClr, done, faultUndef, faultNocp;
  logic [5:0] wrIdx;

  always #2 clk = ~clk;

  rclr_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startIdx(startIdx),
    .regCount(regCount), .isDouble(isDouble), .secureState(secureState),
    .mainExt(mainExt), .fpPresent(fpPresent), .vecPresent(vecPresent),
    .upperBank(upperBank), .fpCtxAutoEn(fpCtxAutoEn), .secFpOwned(secFpOwned),
    .fpAccessOk(fpAccessOk), .busy(busy), .wrEn(wrEn), .wrWide(wrWide),
    .wrIdx(wrIdx), .predClr(predClr), .done(done), .faultUndef(faultUndef),
    .faultNocp(faultNocp)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Expected outcome of one request
  int expN;
  int expW [0:63];
  bit expUndef, expNocp, expPred;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model(input int s, input int c, input bit dbl,
                                input bit sec, input bit mx, input bit fp,
                                input bit vec, input bit up, input bit asp,
                                input bit sf, input bit ok);
    int top, bot, cur;
    expN = 0; expUndef = 0; expNocp = 0; expPred = 0;
    if (!sec || !mx) expUndef = 1;
    else if (!fp && !vec) expPred = 0;
    else if (asp && !sf) expPred = 0;
    else if (!ok) expNocp = 1;
    else if (c == 0) expPred = vec;
    else begin
      top = s + c - 1;
      bot = s;
      if (dbl) begin top = top * 2 + 1; bot = bot * 2; end
      if (top > 63 || (top > 31 && (top % 2) == 0)) expUndef = 1;
      else begin
        if (!up && top > 31) top = 31;
        cur = bot;
        while (cur <= top) begin
          if ((cur % 2) == 1 || cur == top) begin
            expW[expN] = cur; cur = cur + 1;
          end else begin
            expW[expN] = 64 + cur; cur = cur + 2;
          end
          expN++;
        end
        expPred = vec;
      end
    end
  endfunction

  task automatic doOp(input string tag, input int s, input int c, input bit dbl,
                      input bit sec, input bit mx, input bit fp, input bit vec,
                      input bit up, input bit asp, input bit sf, input bit ok,
                      input bit poke);
    int got;
    bit fin;
    @(negedge clk);
    startIdx = 5'(s); regCount = 7'(c); isDouble = dbl;
    secureState = sec; mainExt = mx; fpPresent = fp; vecPresent = vec;
    upperBank = up; fpCtxAutoEn = asp; secFpOwned = sf; fpAccessOk = ok;
    start = 1'b1;
    model(s, c, dbl, sec, mx, fp, vec, up, asp, sf, ok);
    @(negedge clk);
    start = 1'b0;
    got = 0;
    fin = 0;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      if (cyc == 0) chk(tag, "busy after start (R10)", int'(busy), 1);
      if (wrEn) begin
        if (got < expN) chk(tag, "write wide*64+idx (R8)", int'(wrWide) * 64 + int'(wrIdx), expW[got]);
        got++;
      end
      if (done) begin
        fin = 1;
        chk(tag, "write count (R8)", got, expN);
        chk(tag, "done cycle (R10)", cyc, expN);
        chk(tag, "faultUndef (R1/R6)", int'(faultUndef), int'(expUndef));
        chk(tag, "faultNocp (R4)", int'(faultNocp), int'(expNocp));
        chk(tag, "predClr (R9)", int'(predClr), int'(expPred));
      end
      if (poke && cyc == 0) begin
        start = 1'b1;
        startIdx = 5'($urandom_range(0, 31));
        regCount = 7'($urandom_range(0, 40));
        isDouble = ~dbl;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!fin) chk(tag, "done seen (R10)", 0, 1);
    chk(tag, "idle after done (R10)", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      finished = 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "done", int'(done), 0);
    chk("R12", "wrEn", int'(wrEn), 0);
    chk("R12", "faults+pred", int'(faultUndef) + int'(faultNocp) + int'(predClr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    //     tag    s   c  dbl sec mx fp vec up asp sf ok poke
    doOp("R1",    3,  4, 0,  0,  1, 1, 1,  1, 0,  1, 1, 0);
    doOp("R1",    3,  4, 0,  1,  0, 1, 1,  1, 0,  1, 0, 0);
    doOp("R2",    3,  4, 0,  1,  1, 0, 0,  1, 0,  1, 0, 0);
    doOp("R3",    3,  4, 0,  1,  1, 1, 1,  1, 1,  0, 0, 0);
    doOp("R3",    3,  4, 0,  1,  1, 1, 1,  1, 1,  1, 1, 0);
    doOp("R4",   31,  2, 0,  1,  1, 1, 1,  1, 0,  0, 0, 0);
    doOp("R6",   31,  2, 0,  1,  1, 1, 1,  1, 0,  0, 1, 0);
    doOp("R6",   31,  2, 1,  1,  1, 1, 1,  1, 0,  0, 1, 0);
    doOp("R7",   28,  6, 0,  1,  1, 1, 1,  0, 0,  0, 1, 0);
    doOp("R7",   20,  4, 1,  1,  1, 1, 1,  0, 0,  0, 1, 0);
    doOp("R8",    3,  6, 0,  1,  1, 1, 1,  1, 0,  0, 1, 0);
    doOp("R5",    2,  3, 1,  1,  1, 1, 0,  1, 0,  0, 1, 0);
    doOp("R5",   10, 11, 1,  1,  1, 1, 1,  1, 0,  0, 1, 0);
    doOp("R11",   7,  0, 0,  1,  1, 1, 1,  1, 0,  0, 1, 0);
    doOp("R9",    0,  5, 0,  1,  1, 0, 1,  1, 0,  0, 1, 0);
    doOp("R10",   1,  9, 0,  1,  1, 1, 1,  1, 0,  0, 1, 1);

    for (int i = 0; i < 400; i++) begin
      bit dbl, sec, mx, fp, vec, up, asp, sf, ok, pk;
      int s, c;
      s   = $urandom_range(0, 31);
      c   = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 40);
      dbl = $urandom_range(0, 1) == 1;
      sec = $urandom_range(0, 9) != 0;
      mx  = $urandom_range(0, 19) != 0;
      fp  = $urandom_range(0, 7) != 0;
      vec = $urandom_range(0, 1) == 1;
      up  = $urandom_range(0, 1) == 1;
      asp = $urandom_range(0, 1) == 1;
      sf  = $urandom_range(0, 3) != 0;
      ok  = $urandom_range(0, 9) != 0;
      pk  = $urandom_range(0, 4) == 0;
      doOp("R8", s, c, dbl, sec, mx, fp, vec, up, asp, sf, ok, pk);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule